// File: doc/BRIEF.md
# DMA Request Pin Acceptance Controller

This block watches an active-low external DMA request pin for one DMA channel and turns a qualifying level into a held request for the transfer sequencer. Software enables the channel with a configuration write. That write also picks one of two activation styles. In falling-edge style, a new request is taken only after the pin has been seen high again. In low-level style, any low level is enough.

The held request is dropped when the sequencer reports that channel activation has begun. The block then waits in a clear period until the sequencer reports the end of the dead cycle that closes the block transfer. In falling-edge style it also waits for a high sample on the pin before it opens acceptance again. The accept, clear and re-arm loop repeats until the sequencer signals transfer end, or until software disables the channel.

The pin passes through a configurable flop synchronizer before any decision is taken.

Top module: `dreq_gate`

## Requirements
- R1: Synchronous reset drives `req_held` and `accepting` to 0. The synchronizer stages reset to 1, which is the inactive pin level.
- R2: A `cfg_wr` pulse with `cfg_en`=1 opens acceptance (`accepting`=1) on the next clock edge and latches the activation mode from `cfg_edge` (1 = falling-edge style, 0 = low-level style). While the channel is idle, a low pin has no effect.
- R3: While acceptance is open, a pin low level sets `req_held` on the edge after it leaves the synchronizer. With the default two stages, this is the third rising edge after the pin falls, and not the second. `accepting` is 0 while a request is held.
- R4: `req_held` stays set whatever the pin does until `act_start` is seen, and it clears on the next edge. `act_start` while no request is held changes nothing.
- R5: In falling-edge style, if a synchronized high sample occurred during the clear period, then `dead_end` reopens acceptance on the next edge.
- R6: In falling-edge style, if no high sample occurred during the clear period, then `dead_end` leaves acceptance closed. Acceptance reopens on the edge after the first synchronized high sample.
- R7: In low-level style, `dead_end` reopens acceptance on the next edge whatever the pin level. A pin that is still low then sets `req_held` on the following edge.
- R8: Either `xfer_end`, or a `cfg_wr` pulse with `cfg_en`=0, forces `req_held` and `accepting` to 0 on the next edge. `xfer_end` wins over a simultaneous enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Single-cycle configuration write strobe |
| cfg_en | input | 1 | Channel enable value carried by the write |
| cfg_edge | input | 1 | Activation style carried by the write: 1 falling-edge, 0 low-level |
| req_n | input | 1 | External DMA request pin, active low, asynchronous |
| act_start | input | 1 | Sequencer: channel activation begins |
| dead_end | input | 1 | Sequencer: closing dead cycle has ended |
| xfer_end | input | 1 | Sequencer: whole transfer has finished |
| req_held | output | 1 | Request latched and waiting for activation |
| accepting | output | 1 | Pin low level will currently be accepted |

## Verification
The bench builds the block with the default two-stage synchronizer, so each pin change reaches the state logic three edges after it is driven. The bench checks both sides of that latency. It sweeps both activation styles against zero to three high-pin cycles inside the clear period. This covers re-arming before the dead cycle ends, late re-arming after it ends, and level-style reopening with the pin still low. It also covers shutdown both by transfer end and by a disabling write.

// File: rtl/dreq_gate_pkg.sv
package dreq_gate_pkg;

    typedef enum logic {
        ACT_LEVEL = 1'b0,
        ACT_EDGE  = 1'b1
    } act_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_HELD  = 3'd2,
        ST_CLEAR = 3'd3,
        ST_REARM = 3'd4
    } gate_state_t;

    typedef struct packed {
        logic act_start;
        logic dead_end;
        logic xfer_end;
    } seq_status_t;

    typedef struct packed {
        logic      wr;
        logic      en;
        act_mode_t mode;
    } cfg_cmd_t;

    function automatic logic rearm_ok(input act_mode_t m, input logic seen_high);
        return (m == ACT_LEVEL) || seen_high;
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_lvl
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stg;

    initial begin
        if (STAGES < 2) $error("dreq_sync needs at least two stages");
    end

    always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[STAGES-2:0], pin_n};
    end

    assign pin_lvl = stg[LAST];

endmodule

// File: rtl/dreq_rearm.sv
module dreq_rearm (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic watch,
    input  logic pin_lvl,
    output logic high_seen
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear)          seen_q <= 1'b0;
        else if (watch && pin_lvl) seen_q <= 1'b1;
    end

    assign high_seen = seen_q | (watch & pin_lvl);

endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cfg_cmd_t    cfg,
    input  seq_status_t stat,
    input  logic        pin_lvl,
    input  logic        high_seen,
    output gate_state_t state,
    output act_mode_t   mode_q
);
    gate_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_IDLE;
            ST_OPEN:  if (!pin_lvl) nxt = ST_HELD;
            ST_HELD:  if (stat.act_start) nxt = ST_CLEAR;
            ST_CLEAR: if (stat.dead_end)
                          nxt = rearm_ok(mode_q, high_seen) ? ST_OPEN : ST_REARM;
            ST_REARM: if (pin_lvl) nxt = ST_OPEN;
            default:  nxt = ST_IDLE;
        endcase
        if (cfg.wr)        nxt = cfg.en ? ST_OPEN : ST_IDLE;
        if (stat.xfer_end) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= ACT_EDGE;
        end else begin
            state <= nxt;
            if (cfg.wr && cfg.en) mode_q <= cfg.mode;
        end
    end

endmodule

// File: rtl/dreq_gate.sv
module dreq_gate
    import dreq_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic cfg_en,
    input  logic cfg_edge,
    input  logic req_n,
    input  logic act_start,
    input  logic dead_end,
    input  logic xfer_end,
    output logic req_held,
    output logic accepting
);
    cfg_cmd_t    cfg;
    seq_status_t stat;
    gate_state_t state;
    act_mode_t   mode_q;
    logic        pin_lvl;
    logic        high_seen;
    logic        clr_start;
    logic        in_clear;

    assign cfg  = '{wr: cfg_wr, en: cfg_en, mode: act_mode_t'(cfg_edge)};
    assign stat = '{act_start: act_start, dead_end: dead_end, xfer_end: xfer_end};

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (req_n),
        .pin_lvl (pin_lvl)
    );

    assign clr_start = (state == ST_HELD) && act_start;
    assign in_clear  = (state == ST_CLEAR);

    dreq_rearm u_rearm (
        .clk       (clk),
        .rst       (rst),
        .clear     (clr_start),
        .watch     (in_clear),
        .pin_lvl   (pin_lvl),
        .high_seen (high_seen)
    );

    dreq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .stat      (stat),
        .pin_lvl   (pin_lvl),
        .high_seen (high_seen),
        .state     (state),
        .mode_q    (mode_q)
    );

    assign req_held  = (state == ST_HELD);
    assign accepting = (state == ST_OPEN);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!req_held && !accepting)); // R1

    AST_LATCH_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (accepting && !pin_lvl && !xfer_end && !cfg_wr) |=> req_held); // R3

    AST_HOLD_UNTIL_START: assert property (@(posedge clk) disable iff (rst)
        (req_held && !act_start && !xfer_end && !cfg_wr) |=> req_held); // R4

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        (req_held && act_start) |=> !req_held); // R4

    AST_EDGE_WAITS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_clear && mode_q == ACT_EDGE && dead_end && !high_seen && !xfer_end && !cfg_wr)
        |=> !accepting); // R6

    AST_LEVEL_REOPENS: assert property (@(posedge clk) disable iff (rst)
        (in_clear && mode_q == ACT_LEVEL && dead_end && !xfer_end && !cfg_wr)
        |=> accepting); // R7

    AST_END_DROPS: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> (!req_held && !accepting)); // R8

endmodule

// File: tb/dreq_gate_bench.sv
module dreq_gate_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst, cfg_wr, cfg_en, cfg_edge, req_n, act_start, dead_end, xfer_end;
    logic req_held, accepting;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dreq_gate u_dreq_gate (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_en    (cfg_en),
        .cfg_edge  (cfg_edge),
        .req_n     (req_n),
        .act_start (act_start),
        .dead_end  (dead_end),
        .xfer_end  (xfer_end),
        .req_held  (req_held),
        .accepting (accepting)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG && !done) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1; cfg_wr = 0; cfg_en = 0; cfg_edge = 0; req_n = 1;
        act_start = 0; dead_end = 0; xfer_end = 0;
        @(negedge clk);
        step(3);
        rst = 0;
        check("R1 held after reset", req_held, 1'b0);
        check("R1 accepting after reset", accepting, 1'b0);

        // R2: a low pin while idle is ignored
        req_n = 0;
        step(4);
        check("R2 idle pin ignored (held)", req_held, 1'b0);
        check("R2 idle pin ignored (accepting)", accepting, 1'b0);
        req_n = 1;
        step(3);

        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic exp_open;
                cfg_wr = 1; cfg_en = 1; cfg_edge = m[0];
                step();
                cfg_wr = 0;
                check("R2 enable opens", accepting, 1'b1);

                act_start = 1;
                step();
                act_start = 0;
                check("R4 stray start ignored (accepting)", accepting, 1'b1);
                check("R4 stray start ignored (held)", req_held, 1'b0);

                req_n = 0;
                step(2);
                check("R3 not latched before sync", req_held, 1'b0);
                step();
                check("R3 latched", req_held, 1'b1);
                check("R3 closed while held", accepting, 1'b0);

                req_n = 1;
                step(3);
                check("R4 hold survives high pin", req_held, 1'b1);
                req_n = 0;
                step(3);

                act_start = 1;
                step();
                act_start = 0;
                check("R4 start clears held", req_held, 1'b0);
                check("R4 closed in clear period", accepting, 1'b0);

                for (int j = 0; j < k; j++) begin
                    req_n = 1;
                    step();
                end
                req_n = 0;
                step(4);

                dead_end = 1;
                step();
                dead_end = 0;
                exp_open = (m == 0) || (k > 0);
                if (m == 0)      check("R7 level reopens", accepting, exp_open);
                else if (k > 0)  check("R5 edge reopens after high", accepting, exp_open);
                else             check("R6 edge stays closed", accepting, exp_open);

                if (exp_open) begin
                    step();
                    check(m == 0 ? "R7 relatch on low" : "R5 relatch on new fall", req_held, 1'b1);
                    xfer_end = 1;
                    step();
                    xfer_end = 0;
                    check("R8 end drops held", req_held, 1'b0);
                    check("R8 end closes", accepting, 1'b0);
                end else begin
                    req_n = 1;
                    step(2);
                    check("R6 still closed before sync", accepting, 1'b0);
                    step();
                    check("R6 reopens after high", accepting, 1'b1);
                    cfg_wr = 1; cfg_en = 0;
                    step();
                    cfg_wr = 0;
                    check("R8 disable closes", accepting, 1'b0);
                    check("R8 disable held", req_held, 1'b0);
                end
                req_n = 1;
                step(3);
            end
        end

        // R8 priority: end wins over an enabling write
        cfg_wr = 1; cfg_en = 1; cfg_edge = 1; xfer_end = 1;
        step();
        cfg_wr = 0; xfer_end = 0;
        check("R8 end beats enable", accepting, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule